// File: doc/BRIEF.md
# Transmit Interrupt Coalescing Timer

This block decides when a network transmit path raises its transmit-done interrupt cause. Every successfully transmitted descriptor arrives as a one-cycle pulse with two flags: a report-status flag and a delay-enable flag. A descriptor with report-status set and delay-enable clear asks for an interrupt at once. One with both flags set starts two countdowns. The relative countdown restarts on every such completion. The absolute countdown starts only on the first completion and caps how long any completion can wait. A descriptor with report-status clear takes no part.

Both countdowns step once per tick. A prescaler on the core clock makes the tick, and the link-mode input selects its period. With a 125 MHz core clock the defaults give 1.28 µs for the reduced interface (mode 0) and 1.024 µs for the reduced gigabit interface (mode 1). Whatever raises the cause first halts both countdowns, so no stale countdown can raise it again later. The cause bit stays set until software pulses the clear input. It only signals an interrupt and never asks for a descriptor writeback.

Top module: `tx_irq_coalesce`

## Requirements
- R1: During reset and in the first cycle after it, `txDoneCause` is 0 and neither countdown is running.
- R2: A tick occurs every `TICK_CYC_M0` core cycles when `linkMode`=0 and every `TICK_CYC_M1` cycles when `linkMode`=1. A countdown loaded with N therefore raises the cause no earlier than (N-1)·P+1 and no later than N·P cycles after the completion edge, where P is the tick period.
- R3: A completion with report-status=1 and delay-enable=0 sets `txDoneCause` at that same clock edge.
- R4: A completion with report-status=0 sets no cause, and it neither starts nor restarts any countdown.
- R5: A completion with both flags set and a nonzero `relDly` loads the relative countdown with `relDly`. Any later such completion reloads it. When it expires, it sets the cause.
- R6: A completion with both flags set loads the absolute countdown with `absDly` only when that countdown is idle. Later completions do not reload it. When it expires, it sets the cause.
- R7: When `absDly` is 0, the absolute countdown never starts.
- R8: Any event that sets the cause (an immediate completion or the expiry of either countdown) halts both countdowns, so neither raises the cause again without a new completion.
- R9: A completion with both flags set while `relDly` is 0 sets the cause immediately.
- R10: `txDoneCause` stays set until `causeClr` is pulsed. When a set event and the clear fall in the same cycle, the set wins.
- R11: If both countdowns expire on the same tick, the block gives one cause assertion and then stays quiet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| txDone | input | 1 | One-cycle pulse per successfully transmitted descriptor |
| txRs | input | 1 | Report-status flag of that descriptor |
| txIde | input | 1 | Delay-enable flag of that descriptor |
| relDly | input | 16 | Relative delay in ticks |
| absDly | input | 16 | Absolute delay in ticks; 0 disables the ceiling |
| linkMode | input | 1 | Tick period select: 0 gives the longer period, 1 the shorter |
| causeClr | input | 1 | Pulse that clears the transmit-done cause |
| txDoneCause | output | 1 | Sticky transmit-done interrupt cause |

## Verification
Two pairs of events can land in the same cycle. The first pair is a cause-set event and a software clear. The bench provokes it by driving an immediate completion together with `causeClr`, and judges it by requiring the cause to read 1 afterwards. The second pair is the two countdowns expiring together. The bench loads both with equal values and then requires one assertion of the cause, with no second one after a clear. Because the tick phase against a completion is not fixed, every timed result is judged inside the (N-1)·P to N·P window rather than at a single cycle.

// File: rtl/tx_coal_pkg.sv
package tx_coal_pkg;
  localparam int TMR_REL = 0;
  localparam int TMR_ABS = 1;
  localparam int TMR_NUM = 2;

  typedef struct packed {
    logic loadRel;
    logic loadAbs;
    logic stopAll;
  } tmrCtl_t;
endpackage

// File: rtl/tx_coal_tick.sv
module tx_coal_tick #(
  parameter int TICK_CYC_M0 = 160,
  parameter int TICK_CYC_M1 = 128
) (
  input  logic clk,
  input  logic rstN,
  input  logic linkMode,
  output logic tick
);
  localparam int MAX_CYC = (TICK_CYC_M0 > TICK_CYC_M1) ? TICK_CYC_M0 : TICK_CYC_M1;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] LIM0 = CNT_W'(TICK_CYC_M0 - 1);
  localparam logic [CNT_W-1:0] LIM1 = CNT_W'(TICK_CYC_M1 - 1);

  logic [CNT_W-1:0] preCnt;
  logic [CNT_W-1:0] limit;

  assign limit = linkMode ? LIM1 : LIM0;
  assign tick  = (preCnt >= limit);

  always_ff @(posedge clk) begin
    if (!rstN)     preCnt <= '0;
    else if (tick) preCnt <= '0;
    else           preCnt <= preCnt + 1'b1;
  end

  // R2
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tick && $past(rstN) && TICK_CYC_M0 > 1 && TICK_CYC_M1 > 1) |=> !tick);
endmodule

// File: rtl/tx_coal_timers.sv
module tx_coal_timers
  import tx_coal_pkg::*;
#(
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  tmrCtl_t          ctl,
  input  logic [DLY_W-1:0] relVal,
  input  logic [DLY_W-1:0] absVal,
  output logic             relExpire,
  output logic             absExpire,
  output logic             absRunning
);
  logic [DLY_W-1:0] cnt     [TMR_NUM];
  logic [DLY_W-1:0] loadVal [TMR_NUM];
  logic [TMR_NUM-1:0] loadVec;
  logic [TMR_NUM-1:0] expVec;

  assign loadVal[TMR_REL] = relVal;
  assign loadVal[TMR_ABS] = absVal;
  assign loadVec[TMR_REL] = ctl.loadRel;
  assign loadVec[TMR_ABS] = ctl.loadAbs;

  for (genvar i = 0; i < TMR_NUM; i++) begin : g_tmr
    assign expVec[i] = tick && (cnt[i] == DLY_W'(1));
    always_ff @(posedge clk) begin
      if (!rstN)                      cnt[i] <= '0;
      else if (loadVec[i])            cnt[i] <= loadVal[i];
      else if (ctl.stopAll)           cnt[i] <= '0;
      else if (tick && cnt[i] != '0)  cnt[i] <= cnt[i] - 1'b1;
    end
  end

  assign relExpire  = expVec[TMR_REL];
  assign absExpire  = expVec[TMR_ABS];
  assign absRunning = (cnt[TMR_ABS] != '0);

  // R8
  halt_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.stopAll && !ctl.loadAbs && !ctl.loadRel) |=> (cnt[TMR_ABS] == '0 && cnt[TMR_REL] == '0));
  // R7
  abs_load_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadAbs |-> (absVal != '0));
  // R6
  abs_no_reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cnt[TMR_ABS] > DLY_W'(1) && !tick && !ctl.stopAll) |=> (cnt[TMR_ABS] == $past(cnt[TMR_ABS])));
endmodule

// File: rtl/tx_coal_ctrl.sv
module tx_coal_ctrl
  import tx_coal_pkg::*;
#(
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             txDone,
  input  logic             txRs,
  input  logic             txIde,
  input  logic [DLY_W-1:0] relDly,
  input  logic [DLY_W-1:0] absDly,
  input  logic             causeClr,
  input  logic             relExpire,
  input  logic             absExpire,
  input  logic             absRunning,
  output tmrCtl_t          ctl,
  output logic             txDoneCause
);
  logic reportDone;
  logic immediate;
  logic delayed;
  logic anyExpire;
  logic setCause;

  assign reportDone = txDone && txRs;
  assign immediate  = reportDone && (!txIde || relDly == '0);
  assign delayed    = reportDone && txIde && (relDly != '0);
  assign anyExpire  = relExpire || absExpire;
  assign setCause   = immediate || anyExpire;

  always_comb begin
    ctl.loadRel = delayed;
    ctl.loadAbs = delayed && (absDly != '0) && (!absRunning || anyExpire);
    ctl.stopAll = setCause;
  end

  always_ff @(posedge clk) begin
    if (!rstN)         txDoneCause <= 1'b0;
    else if (setCause) txDoneCause <= 1'b1;
    else if (causeClr) txDoneCause <= 1'b0;
  end

  // R10
  cause_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txDoneCause && !causeClr) |=> txDoneCause);
  // R3
  immediate_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txDone && txRs && !txIde) |=> txDoneCause);
  // R4
  rs_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txDone && !txRs) |-> !(ctl.loadRel || ctl.loadAbs));
endmodule

// File: rtl/tx_irq_coalesce.sv
module tx_irq_coalesce
  import tx_coal_pkg::*;
#(
  parameter int DLY_W       = 16,
  parameter int TICK_CYC_M0 = 160,
  parameter int TICK_CYC_M1 = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             txDone,
  input  logic             txRs,
  input  logic             txIde,
  input  logic [DLY_W-1:0] relDly,
  input  logic [DLY_W-1:0] absDly,
  input  logic             linkMode,
  input  logic             causeClr,
  output logic             txDoneCause
);
  tmrCtl_t ctl;
  logic    tick;
  logic    relExpire;
  logic    absExpire;
  logic    absRunning;

  tx_coal_tick #(.TICK_CYC_M0(TICK_CYC_M0), .TICK_CYC_M1(TICK_CYC_M1)) tick_i (
    .clk(clk), .rstN(rstN), .linkMode(linkMode), .tick(tick));

  tx_coal_ctrl #(.DLY_W(DLY_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .txDone(txDone), .txRs(txRs), .txIde(txIde),
    .relDly(relDly), .absDly(absDly), .causeClr(causeClr),
    .relExpire(relExpire), .absExpire(absExpire), .absRunning(absRunning),
    .ctl(ctl), .txDoneCause(txDoneCause));

  tx_coal_timers #(.DLY_W(DLY_W)) timers_i (
    .clk(clk), .rstN(rstN), .tick(tick), .ctl(ctl),
    .relVal(relDly), .absVal(absDly),
    .relExpire(relExpire), .absExpire(absExpire), .absRunning(absRunning));

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rstN |=> !txDoneCause);
endmodule

// File: tb/tx_irq_coalesce_tb_top.sv
module tx_irq_coalesce_tb_top;
  localparam int P0 = 160;
  localparam int P1 = 128;
  localparam int NV = 8;
  localparam logic [7:0] NEVER = 8'hFF;
  // fields: {rs[4], ide[4], relDly[8], absDly[8], expected ticks[8]}; 0 = immediate
  localparam logic [31:0] VEC [NV] = '{
    {4'd1, 4'd0, 8'd5, 8'd5, 8'd0},
    {4'd0, 4'd1, 8'd3, 8'd3, NEVER},
    {4'd0, 4'd0, 8'd3, 8'd3, NEVER},
    {4'd1, 4'd1, 8'd0, 8'd4, 8'd0},
    {4'd1, 4'd1, 8'd3, 8'd0, 8'd3},
    {4'd1, 4'd1, 8'd3, 8'd6, 8'd3},
    {4'd1, 4'd1, 8'd5, 8'd2, 8'd2},
    {4'd1, 4'd1, 8'd4, 8'd4, 8'd4}
  };
  localparam string TAGS [NV] = '{"R3", "R4", "R4", "R9", "R5", "R5", "R6", "R11"};

  logic clk = 1'b0;
  logic rstN, txDone, txRs, txIde, linkMode, causeClr, txDoneCause;
  logic [15:0] relDly, absDly;
  int checkCnt = 0;
  int failCnt  = 0;

  always #5 clk = ~clk;

  tx_irq_coalesce dut_i (
    .clk(clk), .rstN(rstN), .txDone(txDone), .txRs(txRs), .txIde(txIde),
    .relDly(relDly), .absDly(absDly), .linkMode(linkMode),
    .causeClr(causeClr), .txDoneCause(txDoneCause));

  task automatic chk(input string req, input logic act, input logic exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: txDoneCause actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic rs, input logic ide);
    txDone = 1'b1; txRs = rs; txIde = ide;
    @(negedge clk);
    txDone = 1'b0; txRs = 1'b0; txIde = 1'b0;
  endtask

  task automatic clearCause();
    causeClr = 1'b1;
    @(negedge clk);
    causeClr = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checkCnt++; failCnt++;
    $display("FAIL watchdog: all requirements, actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    rstN = 1'b0; txDone = 1'b0; txRs = 1'b0; txIde = 1'b0;
    linkMode = 1'b1; causeClr = 1'b0; relDly = '0; absDly = '0;
    waitCyc(3);
    chk("R1", txDoneCause, 1'b0);
    rstN = 1'b1;
    waitCyc(1);
    chk("R1", txDoneCause, 1'b0);

    // table of single-completion cases, mode 1
    for (int i = 0; i < NV; i++) begin
      logic [31:0] v;
      int expT;
      v = VEC[i];
      relDly = 16'(v[23:16]);
      absDly = 16'(v[15:8]);
      expT = int'(v[7:0]);
      pulse(v[28], v[24]);
      chk(TAGS[i], txDoneCause, expT == 0);
      if (expT == int'(NEVER)) begin
        waitCyc(8 * P1);
        chk(TAGS[i], txDoneCause, 1'b0);
      end else if (expT > 0) begin
        waitCyc((expT - 1) * P1);
        chk(TAGS[i], txDoneCause, 1'b0);
        waitCyc(P1);
        chk(TAGS[i], txDoneCause, 1'b1);
      end
      clearCause();
      waitCyc(8 * P1);
      chk("R8", txDoneCause, 1'b0);
    end

    // R6: absolute ceiling holds while the relative timer keeps restarting
    relDly = 16'd4; absDly = 16'd6;
    pulse(1'b1, 1'b1); waitCyc(2 * P1);
    pulse(1'b1, 1'b1); waitCyc(2 * P1);
    pulse(1'b1, 1'b1); waitCyc(P1 - 2);
    chk("R6", txDoneCause, 1'b0);
    waitCyc(P1);
    chk("R6", txDoneCause, 1'b1);
    clearCause(); waitCyc(8 * P1);

    // R7: same pattern, ceiling disabled, no cause by 6 ticks
    absDly = 16'd0;
    pulse(1'b1, 1'b1); waitCyc(2 * P1);
    pulse(1'b1, 1'b1); waitCyc(2 * P1);
    pulse(1'b1, 1'b1); waitCyc(2 * P1 - 2);
    chk("R7", txDoneCause, 1'b0);
    waitCyc(3 * P1);
    clearCause(); waitCyc(2);

    // R4: report-status clear does not restart a running relative timer
    relDly = 16'd4; absDly = 16'd0;
    pulse(1'b1, 1'b1); waitCyc(2 * P1);
    pulse(1'b0, 1'b1); waitCyc(2 * P1 - 1);
    chk("R4", txDoneCause, 1'b1);
    clearCause(); waitCyc(2);

    // R8: immediate completion halts both countdowns
    relDly = 16'd6; absDly = 16'd8;
    pulse(1'b1, 1'b1); waitCyc(P1);
    pulse(1'b1, 1'b0);
    chk("R8", txDoneCause, 1'b1);
    clearCause(); waitCyc(9 * P1);
    chk("R8", txDoneCause, 1'b0);

    // R10: sticky, and set beats clear in the same cycle
    pulse(1'b1, 1'b0);
    waitCyc(3 * P1);
    chk("R10", txDoneCause, 1'b1);
    clearCause();
    chk("R10", txDoneCause, 1'b0);
    txDone = 1'b1; txRs = 1'b1; txIde = 1'b0; causeClr = 1'b1;
    waitCyc(1);
    txDone = 1'b0; txRs = 1'b0; causeClr = 1'b0;
    chk("R10", txDoneCause, 1'b1);
    clearCause();
    chk("R10", txDoneCause, 1'b0);

    // R2: tick period follows linkMode
    relDly = 16'd10; absDly = 16'd0;
    linkMode = 1'b1; waitCyc(2);
    pulse(1'b1, 1'b1); waitCyc(9 * P1);
    chk("R2", txDoneCause, 1'b0);
    waitCyc(P1);
    chk("R2", txDoneCause, 1'b1);
    clearCause();
    linkMode = 1'b0; waitCyc(2 * P0);
    pulse(1'b1, 1'b1); waitCyc(10 * P1);
    chk("R2", txDoneCause, 1'b0);
    waitCyc(9 * P0 - 10 * P1);
    chk("R2", txDoneCause, 1'b0);
    waitCyc(P0);
    chk("R2", txDoneCause, 1'b1);
    clearCause();

    summary();
    $finish;
  end
endmodule